// File: doc/BRIEF.md
# Set-associative cache tag array

This block keeps the tag bookkeeping of a set-associative cache. Each set holds one record per way. A record is a stored tag and a valid flag. Several independent lookup ports can each present an address with a transaction id. The block splits the address into tag, set index and line offset, reads every way of the addressed set and compares the stored tags with the request tag. It returns hit or miss, the matching way, the request id and the untouched full address. A single update port inserts a tag into selected ways of a set or invalidates them. An update is seen by any lookup whose set read has already been issued but whose result is not yet registered.

After reset a sweep state machine with two states, `ST_SWEEP` and `ST_READY`, clears the valid flag of every set, one set per cycle. The single transition `SWEEP_DONE` fires on the cycle that clears the last set. While in `ST_SWEEP`, lookups are refused and updates are ignored. Each lookup port is a two-register pipeline: a read stage that holds the synchronous set read, then a result register. A result stays frozen until the consumer takes it. The request side stalls when both registers are occupied.

Top module: `cache_tag_array`

## Requirements
- R1: With the default configuration an address splits as tag = bits 31..16, set index = bits 15..6 and line offset = bits 5..0. The offset plays no part in a lookup or an update.
- R2: After reset, `lk_ready` of every port stays 0 for exactly 1024 cycles (one per set). From then on, a lookup of any address misses until an update inserts a record.
- R3: An update with `upd_delete`=0 writes the tag of `upd_addr` into every way whose bit is set in `upd_way_en` (bit w selects way w) and marks it valid. A later lookup with the same tag and set reports `res_found`=1 and `res_way` = that way.
- R4: An update with `upd_delete`=1 invalidates the enabled ways of the set, so that a later lookup no longer hits in them.
- R5: A way hits only when it is valid and its stored tag equals the request tag. The same tag in another set, or another tag in the same set, misses.
- R6: Every result carries the request's id and its full address, offset bits included, unchanged, on both hit and miss.
- R7: When several ways of a set hold the request tag, `res_way` reports the lowest-numbered one.
- R8: While `res_valid`=1 and `res_ready`=0, the port's result outputs hold their values. Once the read stage and the result register are both full, `lk_ready` of that port is 0.
- R9: An update to the looked-up set that is applied on the edge that accepts the lookup, on any edge while the lookup waits in the read stage, or on the edge that loads its result, is reflected in that result.
- R10: Lookup ports operate concurrently. Requests accepted on the same edge on different ports each return their own correct result.
- R11: With `res_ready` held at 1, a result appears exactly two clock edges after the edge that accepts the request. It is not yet valid after the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | PORTS | Lookup request valid, one bit per port |
| lk_ready | output | PORTS | Lookup request accepted when high together with valid |
| lk_addr | input | PORTS*ADDR_W | Lookup address, port p in slice p |
| lk_id | input | PORTS*ID_W | Lookup transaction id, port p in slice p |
| res_valid | output | PORTS | Result valid per port |
| res_ready | input | PORTS | Result consumer ready per port |
| res_found | output | PORTS | 1 when the lookup hit |
| res_way | output | PORTS*WAY_W | Matching way, meaningful only when found |
| res_addr | output | PORTS*ADDR_W | Full address of the request |
| res_id | output | PORTS*ID_W | Id of the request |
| upd_valid | input | 1 | Update request valid (applied on that edge) |
| upd_addr | input | ADDR_W | Address whose tag and set are written |
| upd_way_en | input | WAYS | One-hot way select |
| upd_delete | input | 1 | 1 invalidates, 0 inserts the tag as valid |

## Verification
The two functions that can fall in the same cycle are a lookup and an update to the same set. The update may land on the accept edge, on the result-register edge, or while the result is stalled behind a consumer that holds `res_ready` low. Directed cases place the update on each of these edges. The random phase also attaches updates to lookups at both edges, over a small pool of tags and sets so that collisions are frequent. Each result is judged against a bench model of the records that has already applied every update landing no later than the result-register edge.

// File: rtl/cta_pkg.sv
package cta_pkg;
    typedef enum logic [0:0] {
        ST_SWEEP = 1'b0,
        ST_READY = 1'b1
    } init_state_e;
endpackage

// File: rtl/cta_init_ctrl.sv
module cta_init_ctrl
    import cta_pkg::*;
#(
    parameter int SETS  = 1024,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             sweep_en,
    output logic [IDX_W-1:0] sweep_idx,
    output logic             run
);
    init_state_e      state_q, state_d;
    logic [IDX_W-1:0] cnt_q;

    // state register and sweep counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SWEEP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SWEEP) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // next state: SWEEP_DONE once the last set is cleared
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SWEEP: if (cnt_q == IDX_W'(SETS - 1)) state_d = ST_READY;
            ST_READY: state_d = ST_READY;
        endcase
    end

    // outputs
    always_comb begin
        sweep_en  = 1'b0;
        run       = 1'b0;
        sweep_idx = cnt_q;
        unique case (state_q)
            ST_SWEEP: sweep_en = 1'b1;
            ST_READY: run      = 1'b1;
        endcase
    end
endmodule

// File: rtl/cta_store.sv
module cta_store #(
    parameter int PORTS = 2,
    parameter int WAYS  = 4,
    parameter int SETS  = 1024,
    parameter int IDX_W = 10,
    parameter int REC_W = 17
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [WAYS-1:0]             wr_way_en,
    input  logic [REC_W-1:0]            wr_rec,
    input  logic [PORTS-1:0]            rd_en,
    input  logic [PORTS*IDX_W-1:0]      rd_idx,
    output logic [PORTS*WAYS*REC_W-1:0] rd_row
);
    localparam int ROW_W = WAYS * REC_W;

    logic [ROW_W-1:0] mem [SETS];

    always_ff @(posedge clk) begin
        for (int w = 0; w < WAYS; w++) begin
            if (wr_en && wr_way_en[w]) begin
                mem[wr_idx][w*REC_W +: REC_W] <= wr_rec;
            end
        end
    end

    // per-port snapshot of the read set; kept current by later writes to it
    for (genvar p = 0; p < PORTS; p++) begin : g_rd
        logic [IDX_W-1:0] idx_now;
        logic [IDX_W-1:0] hold_idx_q;
        logic [ROW_W-1:0] row_q;

        assign idx_now = rd_idx[p*IDX_W +: IDX_W];

        always_ff @(posedge clk) begin
            if (rd_en[p]) begin
                hold_idx_q <= idx_now;
                for (int w = 0; w < WAYS; w++) begin
                    if (wr_en && wr_way_en[w] && (wr_idx == idx_now)) begin
                        row_q[w*REC_W +: REC_W] <= wr_rec;
                    end else begin
                        row_q[w*REC_W +: REC_W] <= mem[idx_now][w*REC_W +: REC_W];
                    end
                end
            end else begin
                for (int w = 0; w < WAYS; w++) begin
                    if (wr_en && wr_way_en[w] && (wr_idx == hold_idx_q)) begin
                        row_q[w*REC_W +: REC_W] <= wr_rec;
                    end
                end
            end
        end

        assign rd_row[p*ROW_W +: ROW_W] = row_q;
    end
endmodule

// File: rtl/cta_lookup_port.sv
module cta_lookup_port #(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 4,
    parameter int WAYS   = 4,
    parameter int WAY_W  = 2,
    parameter int IDX_W  = 10,
    parameter int OFS_W  = 6,
    parameter int TAG_W  = 16,
    parameter int REC_W  = 17
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [ID_W-1:0]       req_id,
    output logic                  rd_en,
    output logic [IDX_W-1:0]      rd_idx,
    input  logic [WAYS*REC_W-1:0] row,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [WAYS-1:0]       wr_way_en,
    input  logic [REC_W-1:0]      wr_rec,
    output logic                  res_valid,
    input  logic                  res_ready,
    output logic                  res_found,
    output logic [WAY_W-1:0]      res_way,
    output logic [ADDR_W-1:0]     res_addr,
    output logic [ID_W-1:0]       res_id
);
    logic              s1_v;
    logic [ADDR_W-1:0] s1_addr;
    logic [ID_W-1:0]   s1_id;
    logic              adv;
    logic              fwd;
    logic [IDX_W-1:0]  s1_idx;
    logic [TAG_W-1:0]  s1_tag;
    logic [WAYS-1:0]   hit;
    logic              hit_any;
    logic [WAY_W-1:0]  hit_way;

    assign adv       = !res_valid || res_ready;
    assign req_ready = run && (!s1_v || adv);
    assign rd_en     = req_valid && req_ready;
    assign rd_idx    = req_addr[OFS_W +: IDX_W];
    assign s1_idx    = s1_addr[OFS_W +: IDX_W];
    assign s1_tag    = s1_addr[ADDR_W-1 -: TAG_W];
    assign fwd       = wr_en && (wr_idx == s1_idx);

    // compare each way, with a write on the result-load edge forwarded
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [REC_W-1:0] cur;
        assign cur    = (fwd && wr_way_en[w]) ? wr_rec : row[w*REC_W +: REC_W];
        assign hit[w] = cur[TAG_W] && (cur[TAG_W-1:0] == s1_tag);
    end

    always_comb begin
        hit_any = |hit;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit[w]) hit_way = WAY_W'(w);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v      <= 1'b0;
            res_valid <= 1'b0;
        end else begin
            if (adv) res_valid <= s1_v;
            if (rd_en)    s1_v <= 1'b1;
            else if (adv) s1_v <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            s1_addr <= req_addr;
            s1_id   <= req_id;
        end
        if (adv && s1_v) begin
            res_addr  <= s1_addr;
            res_id    <= s1_id;
            res_found <= hit_any;
            res_way   <= hit_way;
        end
    end
endmodule

// File: rtl/cache_tag_array.sv
module cache_tag_array #(
    parameter int PORTS      = 2,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 64,
    parameter int LINES      = 4096,
    parameter int ADDR_W     = 32,
    parameter int ID_W       = 4,
    localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PORTS-1:0]        lk_valid,
    output logic [PORTS-1:0]        lk_ready,
    input  logic [PORTS*ADDR_W-1:0] lk_addr,
    input  logic [PORTS*ID_W-1:0]   lk_id,
    output logic [PORTS-1:0]        res_valid,
    input  logic [PORTS-1:0]        res_ready,
    output logic [PORTS-1:0]        res_found,
    output logic [PORTS*WAY_W-1:0]  res_way,
    output logic [PORTS*ADDR_W-1:0] res_addr,
    output logic [PORTS*ID_W-1:0]   res_id,
    input  logic                    upd_valid,
    input  logic [ADDR_W-1:0]       upd_addr,
    input  logic [WAYS-1:0]         upd_way_en,
    input  logic                    upd_delete
);
    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam int SETS  = LINES / WAYS;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W;
    localparam int REC_W = TAG_W + 1;
    localparam int ROW_W = WAYS * REC_W;

    logic                   init_done;
    logic                   sweep_en;
    logic [IDX_W-1:0]       sweep_idx;
    logic                   wr_en;
    logic [IDX_W-1:0]       wr_idx;
    logic [WAYS-1:0]        wr_way_en;
    logic [REC_W-1:0]       wr_rec;
    logic [PORTS-1:0]       rd_en;
    logic [PORTS*IDX_W-1:0] rd_idx;
    logic [PORTS*ROW_W-1:0] rd_row;
    logic                   unused_upd_ofs;

    assign unused_upd_ofs = ^upd_addr[OFS_W-1:0];

    cta_init_ctrl #(.SETS(SETS), .IDX_W(IDX_W)) u_init (
        .clk       (clk),
        .rst_n     (rst_n),
        .sweep_en  (sweep_en),
        .sweep_idx (sweep_idx),
        .run       (init_done)
    );

    // write source: sweep clears all ways, otherwise the update port
    always_comb begin
        if (sweep_en) begin
            wr_en     = 1'b1;
            wr_idx    = sweep_idx;
            wr_way_en = '1;
            wr_rec    = '0;
        end else begin
            wr_en     = upd_valid;
            wr_idx    = upd_addr[OFS_W +: IDX_W];
            wr_way_en = upd_way_en;
            wr_rec    = {!upd_delete, upd_addr[ADDR_W-1 -: TAG_W]};
        end
    end

    cta_store #(
        .PORTS(PORTS), .WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W), .REC_W(REC_W)
    ) u_store (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_way_en (wr_way_en),
        .wr_rec    (wr_rec),
        .rd_en     (rd_en),
        .rd_idx    (rd_idx),
        .rd_row    (rd_row)
    );

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        cta_lookup_port #(
            .ADDR_W(ADDR_W), .ID_W(ID_W), .WAYS(WAYS), .WAY_W(WAY_W),
            .IDX_W(IDX_W), .OFS_W(OFS_W), .TAG_W(TAG_W), .REC_W(REC_W)
        ) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (init_done),
            .req_valid (lk_valid[p]),
            .req_ready (lk_ready[p]),
            .req_addr  (lk_addr[p*ADDR_W +: ADDR_W]),
            .req_id    (lk_id[p*ID_W +: ID_W]),
            .rd_en     (rd_en[p]),
            .rd_idx    (rd_idx[p*IDX_W +: IDX_W]),
            .row       (rd_row[p*ROW_W +: ROW_W]),
            .wr_en     (wr_en),
            .wr_idx    (wr_idx),
            .wr_way_en (wr_way_en),
            .wr_rec    (wr_rec),
            .res_valid (res_valid[p]),
            .res_ready (res_ready[p]),
            .res_found (res_found[p]),
            .res_way   (res_way[p*WAY_W +: WAY_W]),
            .res_addr  (res_addr[p*ADDR_W +: ADDR_W]),
            .res_id    (res_id[p*ID_W +: ID_W])
        );
    end
endmodule

// File: rtl/cta_checker.sv
module cta_checker #(
    parameter int PORTS  = 2,
    parameter int ADDR_W = 32,
    parameter int ID_W   = 4,
    parameter int WAY_W  = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    init_done,
    input logic [PORTS-1:0]        lk_valid,
    input logic [PORTS-1:0]        lk_ready,
    input logic [PORTS-1:0]        res_valid,
    input logic [PORTS-1:0]        res_ready,
    input logic [PORTS-1:0]        res_found,
    input logic [PORTS*WAY_W-1:0]  res_way,
    input logic [PORTS*ADDR_W-1:0] res_addr,
    input logic [PORTS*ID_W-1:0]   res_id
);
    assert_no_accept_in_sweep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> (lk_ready == '0));

    assert_sweep_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    for (genvar p = 0; p < PORTS; p++) begin : g_chk
        logic [2:0] outst;
        logic       acc;
        logic       took;

        assign acc  = lk_valid[p] && lk_ready[p];
        assign took = res_valid[p] && res_ready[p];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) outst <= '0;
            else        outst <= outst + 3'(acc) - 3'(took);
        end

        assert_res_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (res_valid[p] && !res_ready[p]) |=>
                (res_valid[p]
                 && $stable(res_found[p])
                 && $stable(res_way[p*WAY_W +: WAY_W])
                 && $stable(res_addr[p*ADDR_W +: ADDR_W])
                 && $stable(res_id[p*ID_W +: ID_W])));

        assert_result_has_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
            res_valid[p] |-> (outst != 3'd0));

        assert_depth_two_R8: assert property (@(posedge clk) disable iff (!rst_n)
            outst <= 3'd2);
    end
endmodule

bind cache_tag_array cta_checker #(
    .PORTS(PORTS), .ADDR_W(ADDR_W), .ID_W(ID_W), .WAY_W(WAY_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_done (init_done),
    .lk_valid  (lk_valid),
    .lk_ready  (lk_ready),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_found (res_found),
    .res_way   (res_way),
    .res_addr  (res_addr),
    .res_id    (res_id)
);

// File: tb/cache_tag_array_tb.sv
`timescale 1ns/1ps
module cache_tag_array_tb;
    localparam int P    = 2;
    localparam int W    = 4;
    localparam int AW   = 32;
    localparam int IW   = 4;
    localparam int WW   = 2;
    localparam int SETS = 1024;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [P-1:0]    lk_valid = '0;
    logic [P-1:0]    lk_ready;
    logic [P*AW-1:0] lk_addr = '0;
    logic [P*IW-1:0] lk_id = '0;
    logic [P-1:0]    res_valid;
    logic [P-1:0]    res_ready = '1;
    logic [P-1:0]    res_found;
    logic [P*WW-1:0] res_way;
    logic [P*AW-1:0] res_addr;
    logic [P*IW-1:0] res_id;
    logic            upd_valid = 1'b0;
    logic [AW-1:0]   upd_addr = '0;
    logic [W-1:0]    upd_way_en = '0;
    logic            upd_delete = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [15:0] m_tag [W][SETS];
    bit          m_v   [W][SETS];

    always #2.5 clk = ~clk;

    cache_tag_array #(.PORTS(P), .WAYS(W), .LINE_BYTES(64), .LINES(4096),
                      .ADDR_W(AW), .ID_W(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
        .lk_addr(lk_addr), .lk_id(lk_id), .res_valid(res_valid),
        .res_ready(res_ready), .res_found(res_found), .res_way(res_way),
        .res_addr(res_addr), .res_id(res_id), .upd_valid(upd_valid),
        .upd_addr(upd_addr), .upd_way_en(upd_way_en), .upd_delete(upd_delete)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk(logic [15:0] tag, logic [9:0] idx, logic [5:0] ofs);
        return {tag, idx, ofs};
    endfunction

    function automatic void model_apply(logic [AW-1:0] a, logic [W-1:0] en, logic del);
        for (int w = 0; w < W; w++) begin
            if (en[w]) begin
                m_v[w][a[15:6]] = !del;
                if (!del) m_tag[w][a[15:6]] = a[31:16];
            end
        end
    endfunction

    function automatic void model_lookup(logic [AW-1:0] a, output logic f, output logic [1:0] wy);
        f = 1'b0;
        wy = 2'd0;
        for (int w = W - 1; w >= 0; w--) begin
            if (m_v[w][a[15:6]] && m_tag[w][a[15:6]] == a[31:16]) begin
                f = 1'b1;
                wy = 2'(w);
            end
        end
    endfunction

    task automatic check_result(int p, logic [AW-1:0] a, logic [IW-1:0] id, string req);
        logic f;
        logic [1:0] wy;
        model_lookup(a, f, wy);
        chk(req, "res_valid", 64'(res_valid[p]), 64'd1);
        chk(req, "res_found", 64'(res_found[p]), 64'(f));
        if (f) chk(req, "res_way", 64'(res_way[p*WW +: WW]), 64'(wy));
        chk("R6", "res_addr", 64'(res_addr[p*AW +: AW]), 64'(a));
        chk("R6", "res_id", 64'(res_id[p*IW +: IW]), 64'(id));
    endtask

    task automatic drive_upd(logic [AW-1:0] a, logic [W-1:0] en, logic del);
        upd_valid = 1'b1;
        upd_addr = a;
        upd_way_en = en;
        upd_delete = del;
        model_apply(a, en, del);
    endtask

    task automatic upd1(logic [AW-1:0] a, logic [W-1:0] en, logic del);
        @(negedge clk);
        drive_upd(a, en, del);
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    // mode 0: plain, 1: update on accept edge, 2: update on result edge
    task automatic lookup1(int p, logic [AW-1:0] a, logic [IW-1:0] id, int mode,
                           logic [AW-1:0] ua, logic [W-1:0] uen, logic udel, string req);
        @(negedge clk);
        lk_valid[p] = 1'b1;
        lk_addr[p*AW +: AW] = a;
        lk_id[p*IW +: IW] = id;
        while (!lk_ready[p]) @(negedge clk);
        if (mode == 1) drive_upd(ua, uen, udel);
        @(negedge clk);
        lk_valid[p] = 1'b0;
        upd_valid = 1'b0;
        chk("R11", "res_valid after one edge", 64'(res_valid[p]), 64'd0);
        if (mode == 2) drive_upd(ua, uen, udel);
        @(negedge clk);
        upd_valid = 1'b0;
        check_result(p, a, id, req);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        int early;
        logic [AW-1:0] a, b, c;
        logic f;
        logic [1:0] wy;
        void'($urandom(32'h5EED_0042));
        for (int w = 0; w < W; w++)
            for (int s = 0; s < SETS; s++) begin
                m_v[w][s] = 0;
                m_tag[w][s] = '0;
            end

        // R2: reset state and sweep length
        repeat (3) @(negedge clk);
        chk("R2", "lk_ready in reset", 64'(lk_ready), 64'd0);
        rst_n = 1'b1;
        n = 0;
        early = 0;
        while (lk_ready[0] !== 1'b1 && n < 5000) begin
            @(negedge clk);
            n++;
            if (n < SETS && lk_ready != '0) early++;
        end
        chk("R2", "sweep cycles", 64'(n), 64'(SETS));
        chk("R2", "ready during sweep", 64'(early), 64'd0);
        lookup1(0, mk(16'h0000, 10'd0, 6'd0), 4'h1, 0, '0, '0, 0, "R2");
        lookup1(1, mk(16'h1234, 10'd1023, 6'd9), 4'h2, 0, '0, '0, 0, "R2");

        // R3, R1: insert, lookup with another offset
        upd1(mk(16'hBEEF, 10'd5, 6'd0), 4'b0100, 1'b0);
        lookup1(0, mk(16'hBEEF, 10'd5, 6'h3F), 4'h3, 0, '0, '0, 0, "R3");
        lookup1(1, mk(16'hBEEF, 10'd5, 6'h11), 4'h4, 0, '0, '0, 0, "R1");
        // R5: other set, other tag
        lookup1(0, mk(16'hBEEF, 10'd6, 6'd0), 4'h5, 0, '0, '0, 0, "R5");
        lookup1(0, mk(16'hBEEE, 10'd5, 6'd0), 4'h6, 0, '0, '0, 0, "R5");
        chk("R5", "miss other tag", 64'(res_found[0]), 64'd0);

        // R7: duplicate tag, lowest way wins
        upd1(mk(16'hCAFE, 10'd9, 6'd0), 4'b1000, 1'b0);
        lookup1(0, mk(16'hCAFE, 10'd9, 6'd0), 4'h7, 0, '0, '0, 0, "R7");
        upd1(mk(16'hCAFE, 10'd9, 6'd0), 4'b0010, 1'b0);
        lookup1(1, mk(16'hCAFE, 10'd9, 6'd0), 4'h8, 0, '0, '0, 0, "R7");
        chk("R7", "lowest way", 64'(res_way[1*WW +: WW]), 64'd1);

        // R4: delete
        upd1(mk(16'hCAFE, 10'd9, 6'd0), 4'b0010, 1'b1);
        lookup1(0, mk(16'hCAFE, 10'd9, 6'd0), 4'h9, 0, '0, '0, 0, "R4");
        upd1(mk(16'hCAFE, 10'd9, 6'd0), 4'b1000, 1'b1);
        lookup1(0, mk(16'hCAFE, 10'd9, 6'd0), 4'hA, 0, '0, '0, 0, "R4");
        chk("R4", "miss after delete", 64'(res_found[0]), 64'd0);

        // R9: update on accept edge and on result edge
        lookup1(0, mk(16'h7777, 10'd20, 6'd0), 4'hB, 1, mk(16'h7777, 10'd20, 6'd0), 4'b0001, 0, "R9");
        chk("R9", "accept-edge insert", 64'(res_found[0]), 64'd1);
        lookup1(1, mk(16'h7777, 10'd20, 6'd0), 4'hC, 2, mk(16'h7777, 10'd20, 6'd0), 4'b0001, 1, "R9");
        chk("R9", "result-edge delete", 64'(res_found[1]), 64'd0);

        // R10: both ports on one edge, with an insert to port 0's set on that edge
        a = mk(16'h4444, 10'd30, 6'd1);
        b = mk(16'hBEEF, 10'd5, 6'd2);
        @(negedge clk);
        lk_valid = 2'b11;
        lk_addr = {b, a};
        lk_id = {4'hE, 4'hD};
        chk("R10", "both ready", 64'(lk_ready), 64'd3);
        drive_upd(a, 4'b0010, 1'b0);
        @(negedge clk);
        lk_valid = '0;
        upd_valid = 1'b0;
        @(negedge clk);
        check_result(0, a, 4'hD, "R10");
        check_result(1, b, 4'hE, "R10");

        // R8: stall with held result; update while lookup waits (R9)
        a = mk(16'hBEEF, 10'd5, 6'd0);
        b = mk(16'h9999, 10'd40, 6'd0);
        c = mk(16'h4444, 10'd30, 6'd0);
        @(negedge clk);
        res_ready[0] = 1'b0;
        lk_valid[0] = 1'b1;
        lk_addr[0 +: AW] = a;
        lk_id[0 +: IW] = 4'h1;
        @(negedge clk);
        lk_addr[0 +: AW] = b;
        lk_id[0 +: IW] = 4'h2;
        chk("R8", "second accepted", 64'(lk_ready[0]), 64'd1);
        @(negedge clk);
        lk_valid[0] = 1'b0;
        drive_upd(b, 4'b0100, 1'b0);
        @(negedge clk);
        upd_valid = 1'b0;
        lk_valid[0] = 1'b1;
        lk_addr[0 +: AW] = c;
        lk_id[0 +: IW] = 4'h3;
        chk("R8", "lk_ready when full", 64'(lk_ready[0]), 64'd0);
        model_lookup(a, f, wy);
        chk("R8", "held found", 64'(res_found[0]), 64'(f));
        chk("R8", "held addr", 64'(res_addr[0 +: AW]), 64'(a));
        @(negedge clk);
        chk("R8", "held id", 64'(res_id[0 +: IW]), 64'h1);
        chk("R8", "still stalled", 64'(lk_ready[0]), 64'd0);
        res_ready[0] = 1'b1;
        @(negedge clk);
        lk_valid[0] = 1'b0;
        check_result(0, b, 4'h2, "R9");
        chk("R9", "stall-time insert", 64'(res_found[0]), 64'd1);
        @(negedge clk);
        check_result(0, c, 4'h3, "R8");

        // random phase
        for (int i = 0; i < 400; i++) begin
            int k;
            logic [9:0] idx;
            logic [AW-1:0] ra, ua;
            k = $urandom % 8;
            idx = (k == 7) ? 10'd1023 : 10'(k);
            ra = mk(16'hA500 + 16'($urandom % 4), idx, 6'($urandom % 64));
            k = $urandom % 8;
            idx = (k == 7) ? 10'd1023 : 10'(k);
            ua = mk(16'hA500 + 16'($urandom % 4), idx, 6'($urandom % 64));
            if ($urandom % 3 == 0) begin
                upd1(ua, 4'b1 << ($urandom % 4), ($urandom % 4) == 0);
            end else begin
                lookup1(int'($urandom % 2), ra, 4'($urandom), int'($urandom % 3),
                        ua, 4'b1 << ($urandom % 4), ($urandom % 4) == 0, "R3");
            end
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule